// File: doc/BRIEF.md
# Carry-Save Tree Multiplier

This block multiplies two unsigned 8-bit operands and delivers the full 16-bit product. One summand row is formed for each multiplier bit: the multiplicand gated by that bit and shifted to its weight. The rows are then reduced level by level. At each level the rows are taken three at a time, and every triple becomes one sum row and one carry row, with no carry travelling along a row. One or two left-over rows pass straight through to the next level. When two rows remain, a single carry-propagate adder joins them.

An optional register stage on the operands and another on the product set the latency to zero, one or two clocks. Both are on by default. One operand pair can be accepted on every clock. The widths are parameters, and the number of reduction levels follows from the operand width. Eight rows need four levels (8, 6, 4, 3, 2).

Top module: `cst_mult`

## Requirements
- R1: For every pair of unsigned 8-bit operands, the 16-bit output equals the exact product of the two operands.
- R2: While the active-low reset is held low, the registered product output reads 0.
- R3: With both register stages enabled, the product of the operands present at clock edge k appears on the output after edge k+1. A new pair is taken on every edge.
- R4: Partial-product row i equals operand A ANDed with bit i of operand B, placed at bit offset i of a 16-bit row. The rows summed modulo 2^16 equal the product of the registered operands.
- R5: Each compressor bit gives sum = XOR of its three inputs and carry = majority of its three inputs, the carry moved up one weight. Added modulo 2^16, the final sum and carry rows equal the product of the registered operands.
- R6: Bit 0 of the final carry row is always 0.
- R7: The carry-out of the final adder is discarded, and the product never exceeds 0xFE01. The operands 0xFF and 0xFF give exactly 0xFE01.
- R8: When either operand is 0, the product is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional operand and product registers |
| rst_n | input | 1 | Asynchronous active-low reset; clears both register stages |
| a_in | input | 8 | Multiplicand, unsigned |
| b_in | input | 8 | Multiplier, unsigned |
| prod | output | 16 | Unsigned product |

## Verification
Assertions check the internal arithmetic on every cycle: that the partial-product rows add up to the product of the registered operands, that the two rows left by the tree add up to the same value, that the final carry row has a zero low bit, and that the product stays within bound. The reset value and the one-clock step from the internal product to the output register are also checked on every cycle. Only the bench scenarios can show that the output is correct and on time for all 65536 operand pairs. The sweep includes the zero operands and the all-ones pair, where a wrong carry-out would show.

// File: rtl/cst_pkg.sv
package cst_pkg;

  // rows left after one 3:2 level acting on n rows
  function automatic int next_rows(input int n);
    return (n / 3) * 2 + (n % 3);
  endfunction

  // rows present at the input of level l, starting from n0 rows
  function automatic int rows_at(input int n0, input int l);
    int n;
    n = n0;
    for (int k = 0; k < l; k++) n = next_rows(n);
    return n;
  endfunction

  // number of compressor levels needed to reach two rows
  function automatic int num_levels(input int n0);
    int n;
    int c;
    n = n0;
    c = 0;
    while (n > 2) begin
      n = next_rows(n);
      c++;
    end
    return c;
  endfunction

  // first row index of level l inside the flat row bus
  function automatic int row_offset(input int n0, input int l);
    int s;
    s = 0;
    for (int k = 0; k < l; k++) s += rows_at(n0, k);
    return s;
  endfunction

  function automatic logic xor3(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/cst_ppgen.sv
module cst_ppgen #(
  parameter int W  = 8,
  parameter int PW = 2 * W
) (
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  output logic [W*PW-1:0]   pp_rows
);
  localparam int PAD = PW - W;

  for (genvar i = 0; i < W; i++) begin : g_row
    logic [W-1:0]  gated;
    logic [PW-1:0] wide;
    assign gated = op_a & {W{op_b[i]}};
    assign wide  = {{PAD{1'b0}}, gated};
    assign pp_rows[i*PW +: PW] = wide << i;
  end
endmodule

// File: rtl/cst_csa_level.sv
module cst_csa_level #(
  parameter int N_IN = 8,
  parameter int PW   = 16,
  localparam int N_OUT = cst_pkg::next_rows(N_IN)
) (
  input  logic [N_IN*PW-1:0]  vin,
  output logic [N_OUT*PW-1:0] vout
);
  localparam int GRP  = N_IN / 3;
  localparam int LEFT = N_IN % 3;

  for (genvar g = 0; g < GRP; g++) begin : g_grp
    logic [PW-1:0] x_r, y_r, z_r;
    logic [PW-1:0] s_r, c_r;
    assign x_r = vin[(3*g)*PW   +: PW];
    assign y_r = vin[(3*g+1)*PW +: PW];
    assign z_r = vin[(3*g+2)*PW +: PW];

    always_comb begin
      c_r[0] = 1'b0;
      for (int j = 0; j < PW; j++) begin
        s_r[j] = cst_pkg::xor3(x_r[j], y_r[j], z_r[j]);
        if (j > 0) c_r[j] = cst_pkg::maj3(x_r[j-1], y_r[j-1], z_r[j-1]);
      end
    end

    assign vout[(2*g)*PW   +: PW] = s_r;
    assign vout[(2*g+1)*PW +: PW] = c_r;
  end

  for (genvar k = 0; k < LEFT; k++) begin : g_pass
    assign vout[(2*GRP+k)*PW +: PW] = vin[(3*GRP+k)*PW +: PW];
  end
endmodule

// File: rtl/cst_reduce.sv
module cst_reduce #(
  parameter int W  = 8,
  parameter int PW = 2 * W
) (
  input  logic [W*PW-1:0] pp_rows,
  output logic [PW-1:0]   red_sum,
  output logic [PW-1:0]   red_car
);
  localparam int NL   = cst_pkg::num_levels(W);
  localparam int TOT  = cst_pkg::row_offset(W, NL + 1);
  localparam int LAST = cst_pkg::row_offset(W, NL);

  logic [TOT*PW-1:0] row_bus;

  assign row_bus[0 +: W*PW] = pp_rows;

  for (genvar l = 0; l < NL; l++) begin : g_lvl
    localparam int NI  = cst_pkg::rows_at(W, l);
    localparam int NO  = cst_pkg::rows_at(W, l + 1);
    localparam int OFI = cst_pkg::row_offset(W, l);
    localparam int OFO = cst_pkg::row_offset(W, l + 1);

    cst_csa_level #(.N_IN(NI), .PW(PW)) u_lvl (
      .vin  (row_bus[OFI*PW +: NI*PW]),
      .vout (row_bus[OFO*PW +: NO*PW])
    );
  end

  assign red_sum = row_bus[LAST*PW       +: PW];
  assign red_car = row_bus[(LAST+1)*PW   +: PW];
endmodule

// File: rtl/cst_cpa.sv
module cst_cpa #(
  parameter int PW = 16
) (
  input  logic [PW-1:0] x_in,
  input  logic [PW-1:0] y_in,
  output logic [PW-1:0] s_out
);
  // carry chain stops at the top bit: the carry-out is never formed
  logic [PW-1:0] cy;

  assign cy[0] = 1'b0;

  for (genvar j = 0; j < PW; j++) begin : g_bit
    assign s_out[j] = cst_pkg::xor3(x_in[j], y_in[j], cy[j]);
    if (j < PW - 1) begin : g_cy
      assign cy[j+1] = cst_pkg::maj3(x_in[j], y_in[j], cy[j]);
    end
  end
endmodule

// File: rtl/cst_mult.sv
module cst_mult #(
  parameter int W       = 8,
  parameter bit IN_REG  = 1'b1,
  parameter bit OUT_REG = 1'b1,
  localparam int PW     = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  a_in,
  input  logic [W-1:0]  b_in,
  output logic [PW-1:0] prod
);
  logic [W-1:0]    op_a, op_b;
  logic [W*PW-1:0] pp_rows;
  logic [PW-1:0]   red_sum, red_car;
  logic [PW-1:0]   prod_comb;

  if (IN_REG) begin : g_in_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        op_a <= '0;
        op_b <= '0;
      end else begin
        op_a <= a_in;
        op_b <= b_in;
      end
    end
  end else begin : g_in_wire
    assign op_a = a_in;
    assign op_b = b_in;
  end

  cst_ppgen #(.W(W), .PW(PW)) u_ppgen (
    .op_a    (op_a),
    .op_b    (op_b),
    .pp_rows (pp_rows)
  );

  cst_reduce #(.W(W), .PW(PW)) u_reduce (
    .pp_rows (pp_rows),
    .red_sum (red_sum),
    .red_car (red_car)
  );

  cst_cpa #(.PW(PW)) u_cpa (
    .x_in  (red_sum),
    .y_in  (red_car),
    .s_out (prod_comb)
  );

  if (OUT_REG) begin : g_out_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod <= '0;
      else        prod <= prod_comb;
    end
  end else begin : g_out_wire
    assign prod = prod_comb;
  end
endmodule

// File: rtl/cst_mult_chk.sv
module cst_mult_chk #(
  parameter int W       = 8,
  parameter bit IN_REG  = 1'b1,
  parameter bit OUT_REG = 1'b1,
  localparam int PW     = 2 * W
) (
  input logic            clk,
  input logic            rst_n,
  input logic [W-1:0]    op_a,
  input logic [W-1:0]    op_b,
  input logic [W*PW-1:0] pp_rows,
  input logic [PW-1:0]   red_sum,
  input logic [PW-1:0]   red_car,
  input logic [PW-1:0]   prod_comb,
  input logic [PW-1:0]   prod
);
  localparam logic [PW-1:0] MAXP = PW'(((1 << W) - 1) * ((1 << W) - 1));

  logic [PW-1:0] want, row_total, pair_total;

  always_comb begin
    want = PW'({{W{1'b0}}, op_a} * {{W{1'b0}}, op_b});
    row_total = '0;
    for (int i = 0; i < W; i++) row_total = row_total + pp_rows[i*PW +: PW];
    pair_total = red_sum + red_car;
  end

  a_r4_rows_add_up: assert property (@(posedge clk) disable iff (!rst_n)
    row_total == want);

  a_r5_tree_keeps_value: assert property (@(posedge clk) disable iff (!rst_n)
    pair_total == want);

  a_r6_carry_lsb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    red_car[0] == 1'b0);

  a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_comb <= MAXP) && (prod <= MAXP));

  a_r1_exact: assert property (@(posedge clk) disable iff (!rst_n)
    prod_comb == want);

  if (OUT_REG) begin : g_out_chk
    a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      prod == $past(prod_comb));

    always @(negedge clk) begin
      if (!rst_n) begin
        a_r2_reset_clear: assert (prod == '0);
      end
    end
  end
endmodule

bind cst_mult cst_mult_chk #(.W(W), .IN_REG(IN_REG), .OUT_REG(OUT_REG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_a      (op_a),
  .op_b      (op_b),
  .pp_rows   (pp_rows),
  .red_sum   (red_sum),
  .red_car   (red_car),
  .prod_comb (prod_comb),
  .prod      (prod)
);

// File: tb/cst_mult_bench.sv
module cst_mult_bench;
  localparam int W   = 8;
  localparam int PW  = 2 * W;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  a = '0;
  logic [W-1:0]  b = '0;
  logic [PW-1:0] p;

  always #5 clk = ~clk;

  cst_mult #(.W(W), .IN_REG(1'b1), .OUT_REG(1'b1)) u_cst_mult (
    .clk   (clk),
    .rst_n (rst_n),
    .a_in  (a),
    .b_in  (b),
    .prod  (p)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int unsigned exp_q[$];
  int unsigned exp_now = 0;
  bit model_on = 1'b0;

  // behavioural model: a product pushed at one edge is due LAT-1 edges later
  always @(posedge clk) begin
    if (model_on) begin
      exp_q.push_back(int'(a) * int'(b));
      exp_now = exp_q.pop_front();
    end
  end

  task automatic check(input string tag, input int unsigned got, input int unsigned expv);
    n_cmp++;
    if (got != expv) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, expv);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #1500us;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R2: output held at zero through reset
    repeat (3) begin
      @(negedge clk);
      check("R2 reset", int'(p), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < LAT - 1; k++) exp_q.push_back(0);
    model_on = 1'b1;

    // full sweep, one pair per clock, checked on every clock
    for (int ia = 0; ia < 256; ia++) begin
      for (int ib = 0; ib < 256; ib++) begin
        @(negedge clk);
        if (exp_now == 0)            check("R8 zero operand", int'(p), exp_now);
        else if (exp_now == 65025)   check("R7 max operands", int'(p), exp_now);
        else                         check("R1 R3 R4 R5 R6 product", int'(p), exp_now);
        a = W'(ia);
        b = W'(ib);
      end
    end

    // drain the pipeline
    repeat (LAT + 1) begin
      @(negedge clk);
      check("R3 drain", int'(p), exp_now);
      a = '0;
      b = '0;
    end
    finish_run();
  end
endmodule